// File: doc/BRIEF.md
# UART Baud Strobe Generator with High-Speed Mode

This block makes the 16x sampling enable for a UART transmitter and receiver. It runs on a 7.3728 MHz reference clock. It takes three inputs: a 16-bit divisor from the divisor latch, a write pulse that fires whenever either divisor byte is rewritten, and a high-speed enable bit from a configuration register. From these it produces `tick`, a one-cycle enable pulse in the reference clock domain.

In standard mode the reference is divided by four times the divisor. Divisor 1 therefore gives a 1.8432 MHz strobe (115200 baud), divisor 12 gives 9600 baud, and divisor 2304 gives 50 baud. In this mode the high-speed bit has no effect.

When the high-speed bit is set and bit 15 of the divisor is 1, the low 15 bits of the divisor are used directly as the divide count. Divisor 0x8002 then gives 230400 baud and divisor 0x8001 gives 460800 baud. A divide count of zero stops the strobe. Rewriting the divisor, or changing the high-speed bit, restarts the count phase.

Top module: `uart_baud_gen`

## Requirements
- R1: With `hs_en` low, `tick` is a single-cycle pulse repeating every 4 × `divisor` clock cycles (divisor 1 → every 4 cycles, 12 → 48, 2304 → 9216).
- R2: When `divisor[15]` is 0, the tick period is 4 × `divisor` whatever the level of `hs_en` (divisor 12 and divisor 3 give the same period with `hs_en` high or low).
- R3: With `hs_en` high and `divisor[15]` = 1, the tick period equals `divisor[14:0]` cycles (0x8001 → a tick every cycle, 0x8002 → every 2 cycles).
- R4: With `hs_en` low, `divisor[15]` counts as an ordinary magnitude bit (0x8001 → period 131076 cycles).
- R5: A divide count of zero (divisor 0, or 0x8000 with `hs_en` high) produces no tick at all.
- R6: A clock edge that samples `div_wr` high clears the count phase. The first tick after it appears exactly one period after that edge, even when the write lands in the middle of a period.
- R7: A clock edge that samples `hs_en` different from its value at the previous edge restarts the count phase in the same way as R6.
- R8: The synchronous reset `rst` holds `tick` low and clears the count. The first tick follows one period after the last edge that samples `rst` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 7.3728 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_wr | input | 1 | Pulse: a divisor byte was written this cycle |
| divisor | input | 16 | Divisor latch value |
| hs_en | input | 1 | High-speed enable from the configuration register |
| tick | output | 1 | One-cycle 16x sampling enable |

## Verification
The embedded properties assume that `divisor` changes only in a cycle where `div_wr` is high, or during reset. Under that assumption the divide count cannot move under the counter without a restart, so the counter always stays below the count. The stimulus keeps to this rule: each new divisor value is presented together with a one-cycle write pulse and is then held until the next write. `hs_en` is driven only at falling clock edges, so every change is seen cleanly at the next rising edge.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;

   typedef enum logic [0:0] {
      RATE_STD  = 1'b0,
      RATE_FAST = 1'b1
   } rate_mode_e;

   function automatic int unsigned prescale_shift(input int unsigned pre);
      int unsigned s;
      s = 0;
      while ((1 << s) < pre) s++;
      return s;
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/baud_div_map.sv
module baud_div_map
   import uart_baud_pkg::*;
#(
   parameter int unsigned DIV_W    = 16,
   parameter int unsigned PRESCALE = 4,
   parameter int unsigned CNT_W    = DIV_W + prescale_shift(PRESCALE)
) (
   input  logic [DIV_W-1:0] divisor,
   input  logic             hs_en,
   output logic [CNT_W-1:0] eff_count,
   output rate_mode_e       mode
);

   localparam int unsigned PRE_SH = prescale_shift(PRESCALE);

   logic [CNT_W-1:0] std_count;
   logic [CNT_W-1:0] fast_count;

   generate
      if (DIV_W < 2) begin : g_bad_width
         $error("baud_div_map: DIV_W must be at least 2");
      end
      if (CNT_W < DIV_W + PRE_SH) begin : g_bad_cnt
         $error("baud_div_map: CNT_W too narrow for the scaled divisor");
      end

      if (PRESCALE == 1) begin : g_pre_none
         assign std_count = CNT_W'(divisor);
      end else if (is_pow2(PRESCALE)) begin : g_pre_shift
         assign std_count = CNT_W'(divisor) << PRE_SH;
      end else begin : g_pre_mult
         assign std_count = CNT_W'(divisor) * CNT_W'(PRESCALE);
      end
   endgenerate

   assign fast_count = CNT_W'(divisor[DIV_W-2:0]);

   always_comb begin
      if (hs_en && divisor[DIV_W-1]) mode = RATE_FAST;
      else                           mode = RATE_STD;
   end

   always_comb begin
      unique case (mode)
         RATE_FAST: eff_count = fast_count;
         default:   eff_count = std_count;
      endcase
   end

endmodule

// File: rtl/baud_restart.sv
module baud_restart (
   input  logic clk,
   input  logic rst,
   input  logic div_wr,
   input  logic hs_en,
   output logic restart
);

   logic hs_q;

   always_ff @(posedge clk) begin
      hs_q <= hs_en;
   end

   assign restart = !rst && (div_wr || (hs_en != hs_q));

   AST_HS_EDGE_RESTART: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && hs_en != $past(hs_en)) |-> restart) else $error("hs change without restart"); // R7

   AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (rst)
      div_wr |-> restart) else $error("write without restart"); // R6

endmodule

// File: rtl/baud_tick_ctr.sv
module baud_tick_ctr #(
   parameter int unsigned CNT_W = 18
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart,
   input  logic [CNT_W-1:0] eff_count,
   output logic             tick
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt;
   logic             at_end;
   logic             idle;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("baud_tick_ctr: CNT_W must be at least 2");
      end
   endgenerate

   assign idle   = (eff_count == '0);
   assign at_end = (cnt == eff_count - ONE);

   always_ff @(posedge clk) begin
      if (rst || restart || idle) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (at_end) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + ONE;
         tick <= 1'b0;
      end
   end

   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
      restart |=> (cnt == '0 && !tick)) else $error("restart did not clear"); // R6

   AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
      (eff_count == '0) |=> !tick) else $error("tick with zero count"); // R5

   AST_TERMINAL_TICK: assert property (@(posedge clk) disable iff (rst)
      (!restart && eff_count != '0 && cnt == eff_count - ONE) |=> tick) else $error("missed tick"); // R1

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(restart) && eff_count != '0 && $stable(eff_count)) |-> (cnt < eff_count))
      else $error("count out of range"); // R1

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (!tick && cnt == '0)) else $error("reset state wrong"); // R8

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
   import uart_baud_pkg::*;
#(
   parameter int unsigned DIV_W    = 16,
   parameter int unsigned PRESCALE = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             div_wr,
   input  logic [DIV_W-1:0] divisor,
   input  logic             hs_en,
   output logic             tick
);

   localparam int unsigned CNT_W = DIV_W + prescale_shift(PRESCALE);

   logic [CNT_W-1:0] eff_count;
   rate_mode_e       mode;
   logic             restart;

   generate
      if (PRESCALE < 1) begin : g_bad_pre
         $error("uart_baud_gen: PRESCALE must be at least 1");
      end
   endgenerate

   baud_div_map #(
      .DIV_W    (DIV_W),
      .PRESCALE (PRESCALE),
      .CNT_W    (CNT_W)
   ) u_map (
      .divisor   (divisor),
      .hs_en     (hs_en),
      .eff_count (eff_count),
      .mode      (mode)
   );

   baud_restart u_restart (
      .clk     (clk),
      .rst     (rst),
      .div_wr  (div_wr),
      .hs_en   (hs_en),
      .restart (restart)
   );

   baud_tick_ctr #(
      .CNT_W (CNT_W)
   ) u_ctr (
      .clk       (clk),
      .rst       (rst),
      .restart   (restart),
      .eff_count (eff_count),
      .tick      (tick)
   );

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
      (tick && eff_count > CNT_W'(1) && !restart) |=> !tick) else $error("tick too wide"); // R1

   AST_FAST_IGNORES_PRESCALE: assert property (@(posedge clk) disable iff (rst)
      (mode == RATE_FAST && !divisor[DIV_W-1]) |-> 1'b0) else $error("fast mode without top bit"); // R2

endmodule

// File: tb/uart_baud_gen_test.sv
module uart_baud_gen_test;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 199000;

   logic        clk = 1'b0;
   logic        rst;
   logic        div_wr;
   logic [15:0] divisor;
   logic        hs_en;
   logic        tick;

   int    cyc = 0;
   int    n_cmp = 0;
   int    n_bad = 0;
   int    exp_cyc[$];
   string exp_tag[$];
   string cur_tag = "R8";
   bit    done = 1'b0;

   uart_baud_gen uut (
      .clk     (clk),
      .rst     (rst),
      .div_wr  (div_wr),
      .divisor (divisor),
      .hs_en   (hs_en),
      .tick    (tick)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pops expected tick cycles and compares
   always @(negedge clk) begin
      if (!rst && tick) begin
         n_cmp++;
         if (exp_cyc.size() == 0) begin
            n_bad++;
            $display("FAIL %s: unexpected tick at cycle %0d, expected none", cur_tag, cyc);
         end else begin
            if (exp_cyc[0] != cyc) begin
               n_bad++;
               $display("FAIL %s: tick at cycle %0d, expected cycle %0d", exp_tag[0], cyc, exp_cyc[0]);
            end
            void'(exp_cyc.pop_front());
            void'(exp_tag.pop_front());
         end
      end
   end

   // driver: called just after a falling edge
   task automatic seg(input logic [15:0] d, input logic hs, input logic wr,
                      input int period, input int n, input int tail, input string tag);
      int c0;
      divisor = d;
      hs_en   = hs;
      div_wr  = wr;
      cur_tag = tag;
      c0 = cyc + 1;              // edge that samples the restart
      for (int k = 1; k <= n; k++) begin
         exp_cyc.push_back(c0 + k * period);
         exp_tag.push_back(tag);
      end
      @(negedge clk);
      div_wr = 1'b0;
      while (cyc < c0 + n * period + tail) @(negedge clk);
      #1;
      n_cmp++;
      if (exp_cyc.size() != 0) begin
         n_bad++;
         $display("FAIL %s: %0d ticks missing, expected 0 missing", tag, exp_cyc.size());
         exp_cyc.delete();
         exp_tag.delete();
      end
   endtask

   initial begin
      rst = 1'b1; div_wr = 1'b0; divisor = 16'd1; hs_en = 1'b0;
      repeat (3) @(negedge clk);
      n_cmp++;
      if (tick !== 1'b0) begin
         n_bad++;
         $display("FAIL R8: tick=%b during reset, expected 0", tick);
      end
      // R8: release reset, divisor 1 held -> first tick 4 cycles after last reset edge
      begin
         int c0;
         c0 = cyc;
         rst = 1'b0;
         for (int k = 1; k <= 5; k++) begin
            exp_cyc.push_back(c0 + 4 * k);
            exp_tag.push_back("R8");
         end
         while (cyc < c0 + 20) @(negedge clk);
         #1;
         n_cmp++;
         if (exp_cyc.size() != 0) begin
            n_bad++;
            $display("FAIL R8: %0d ticks missing, expected 0 missing", exp_cyc.size());
            exp_cyc.delete(); exp_tag.delete();
         end
      end
      seg(16'd12,    1'b0, 1'b1, 48,   3, 20, "R1");   // R1, then partial period
      seg(16'd12,    1'b1, 1'b1, 48,   3, 0,  "R2");   // R2 hs ignored, R6 mid restart
      seg(16'd12,    1'b0, 1'b0, 48,   2, 30, "R7");   // R7 hs change only
      seg(16'd3,     1'b1, 1'b1, 12,   3, 5,  "R2");
      seg(16'h8001,  1'b1, 1'b1, 1,   10, 0,  "R3");
      seg(16'h8002,  1'b1, 1'b1, 2,    6, 1,  "R3");
      seg(16'h8000,  1'b1, 1'b1, 1,    0, 60, "R5");
      seg(16'd0,     1'b0, 1'b1, 1,    0, 40, "R5");
      seg(16'd2304,  1'b0, 1'b1, 9216, 2, 100,"R1");
      seg(16'd2,     1'b0, 1'b1, 8,    2, 5,  "R6");   // R6 write mid-period
      seg(16'h8001,  1'b0, 1'b1, 131076, 1, 0, "R4");
      done = 1'b1;
   end

   initial begin
      while (!done && cyc < WATCHDOG) @(negedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: cycle %0d, expected completion before %0d", cyc, WATCHDOG);
      end
      #1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule